// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block shifts one character out on a single serial line. A word is offered together with a one-cycle start pulse. The block snapshots the word and the format fields into a single holding shift register, then sends the frame bit by bit and raises a busy flag for the whole transfer. One datapath serves three formats. The first is a plain asynchronous frame: a low start bit, 7 or 8 data bits, an optional parity bit and one or two high stop bits. The second is an asynchronous frame in which an address-flag bit takes the place of parity. The third is a clocked synchronous transfer of 8 bare data bits.

Bit timing comes from a base tick. In the asynchronous formats 16 ticks make one bit time. The tick is either the internal divider pulse or the rising edge of an external clock pin, which passes through a synchronizer first. In synchronous mode the block can drive the serial clock itself. It can also follow an external serial clock and advance on that clock's falling edges. A two-bit clock-select field decides whether the serial clock pin is unused, driven, or read.

Top module: `frame_tx`

## Requirements
- R1: While reset is asserted and whenever the block is idle, `serOut` is 1, `busy` is 0 and `serClkOut` is 1.
- R2: A `start` pulse seen while `busy` is 0 sets `busy` on the next clock edge, and the first frame bit appears on `serOut` at that edge. A `start` seen while `busy` is 1 is ignored and does not disturb the frame in flight.
- R3: An asynchronous frame (`modeSync`=0) begins with a 0 start bit and then sends the data least significant bit first. It sends 8 data bits when `char7`=0 and the low 7 bits when `char7`=1.
- R4: With `addrFlagEn`=0 and `parEn`=1, one parity bit follows the data bits. It is computed over the bits actually sent: even parity when `parOdd`=0 and odd parity when `parOdd`=1. With `parEn`=0 no parity bit is sent.
- R5: With `addrFlagEn`=1 in asynchronous mode, one address-flag bit follows the data and no parity bit is sent, whatever `parEn` is. The flag's value is `addrFlagIn` as sampled with the accepted `start`.
- R6: Every asynchronous frame ends with one stop bit of value 1 when `stop2`=0, or two when `stop2`=1. `busy` falls at the end of the last stop bit.
- R7: In asynchronous mode each bit lasts exactly 16 base ticks. With `clkSel[1]`=0 the base tick is the `tick` input, and cycles without `tick` do not advance the frame.
- R8: In asynchronous mode `serClkOe` is 1 only when `clkSel`=01. While a frame is sent with internal ticks, `serClkOut` is 0 during base ticks 0 to 7 of each bit and 1 during ticks 8 to 15.
- R9: In asynchronous mode with `clkSel[1]`=1, `serClkOe` is 0 and the base tick is a rising edge of `serClkIn`. That pin passes a two-flop synchronizer, so a rising edge that is first sampled at clock edge k is counted at edge k+2. `tick` is then ignored.
- R10: In synchronous mode (`modeSync`=1) a frame is exactly 8 data bits, least significant bit first, with no start, stop, parity or address-flag bit. `char7`, `parEn`, `parOdd`, `addrFlagEn` and `stop2` have no effect.
- R11: In synchronous mode with `clkSel[1]`=0, `serClkOe` is 1 and each bit lasts 16 ticks. `serClkOut` is 0 for the first 8 ticks of a bit and 1 for the last 8, so `serOut` changes together with a falling serial-clock edge.
- R12: In synchronous mode with `clkSel[1]`=1, `serClkOe` is 0. Each synchronized falling edge of `serClkIn` (counted two clock edges after it is first sampled) moves `serOut` to the next bit. The frame ends on the 8th such edge.
- R13: The format fields and the clock source are captured when a frame is accepted. Changing them during the frame does not alter that frame. `serClkOe` follows the live `modeSync` and `clkSel` inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Internal base tick from the rate divider |
| start | input | 1 | One-cycle request to send `txData` |
| txData | input | 8 | Word to send |
| addrFlagIn | input | 1 | Value of the address-flag bit, sampled with `start` |
| modeSync | input | 1 | 1 selects clocked synchronous mode |
| char7 | input | 1 | 1 selects 7 data bits (async only) |
| parEn | input | 1 | Adds a parity bit (async, flag mode off) |
| parOdd | input | 1 | 1 selects odd parity |
| addrFlagEn | input | 1 | Sends an address-flag bit instead of parity |
| stop2 | input | 1 | 1 selects two stop bits |
| clkSel | input | 2 | Serial clock source and pin direction select |
| serClkIn | input | 1 | External serial clock pin input |
| serOut | output | 1 | Serial data line |
| busy | output | 1 | A frame is in progress |
| serClkOut | output | 1 | Serial clock driven by the block |
| serClkOe | output | 1 | Output enable for `serClkOut` |

## Verification
On every cycle the assertions check the idle state of the data and clock lines and that an accepted start raises busy. They also check that the first bit is the start bit in asynchronous frames and the least significant data bit in synchronous ones, and that the bit sent just before an asynchronous frame ends is a stop bit. The bench's reference model is the only way to show the full bit sequence of each format: parity values, the address-flag latch, 7-bit truncation, the 16-tick bit length under a sparse tick, synchronizer latency on external clocks, and immunity to format changes and repeated starts during a frame.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  // Character format captured with each accepted frame.
  typedef struct packed {
    logic syncMode;
    logic char7;
    logic parEn;
    logic parOdd;
    logic addrEn;
    logic stop2;
  } txFmtT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic shift;
  } txStrbT;

  // Number of bit times in one frame for a given format.
  function automatic int unsigned frameBits(txFmtT f, int unsigned dataW);
    int unsigned n;
    if (f.syncMode) begin
      n = dataW;
    end else begin
      n = 1 + (f.char7 ? dataW - 1 : dataW);
      if (f.addrEn || f.parEn) n = n + 1;
      n = n + (f.stop2 ? 2 : 1);
    end
    return n;
  endfunction

endpackage

// File: rtl/frame_tx_edge.sv
module frame_tx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseSeen,
  output logic fallSeen
);
  logic [STAGES:0] shiftQ;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("frame_tx_edge needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[STAGES-1:0], pinIn};
  end

  // shiftQ[STAGES-1] is the synchronized level, shiftQ[STAGES] its previous value.
  assign riseSeen = shiftQ[STAGES-1] & ~shiftQ[STAGES];
  assign fallSeen = ~shiftQ[STAGES-1] & shiftQ[STAGES];
endmodule

// File: rtl/frame_tx_dp.sv
module frame_tx_dp
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  txStrbT                   strb,
  input  txFmtT                    fmtIn,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic                     flagIn,
  output logic [$clog2(DATA_W+5)-1:0] frameLen,
  output logic                     lineOut
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(DATA_W + 5);

  logic [FRAME_W-1:0] frameQ, frameNext;
  logic [DATA_W-1:0]  dataMask, dataSent;
  logic               parBit, extraBit, extraOn;

  // Mask of data bits actually sent: top bit dropped for short characters.
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
      if (b == DATA_W - 1) begin : g_top
        assign dataMask[b] = fmtIn.syncMode | ~fmtIn.char7;
      end else begin : g_low
        assign dataMask[b] = 1'b1;
      end
    end
  endgenerate

  assign dataSent = dataIn & dataMask;
  assign parBit   = (^dataSent) ^ fmtIn.parOdd;
  assign extraBit = fmtIn.addrEn ? flagIn : parBit;
  assign extraOn  = fmtIn.addrEn | fmtIn.parEn;

  always_comb begin
    frameNext = '1;
    if (fmtIn.syncMode) begin
      frameNext[DATA_W-1:0] = dataIn;
    end else begin
      frameNext[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (dataMask[i]) frameNext[i+1] = dataIn[i];
      end
      if (extraOn) begin
        if (fmtIn.char7) frameNext[DATA_W]   = extraBit;
        else             frameNext[DATA_W+1] = extraBit;
      end
    end
  end

  assign frameLen = CNT_W'(frameBits(fmtIn, DATA_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '1;
    end else if (strb.load) begin
      frameQ <= frameNext;
    end else if (strb.shift) begin
      frameQ <= {1'b1, frameQ[FRAME_W-1:1]};
    end
  end

  assign lineOut = frameQ[0];
endmodule

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        syncIn,
  input  logic                        extIn,
  input  logic [$clog2(DATA_W+5)-1:0] lenIn,
  input  logic                        tick,
  input  logic                        pinRise,
  input  logic                        pinFall,
  output txStrbT                      strb,
  output logic                        busy,
  output logic                        clkPhaseOut,
  output logic                        frameSync
);
  localparam int CNT_W = $clog2(DATA_W + 5);
  localparam int PH_W  = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(OVERSAMPLE / 2);

  logic             busyQ, syncQ, extQ;
  logic [CNT_W-1:0] leftQ;
  logic [PH_W-1:0]  phaseQ;
  logic             baseTick, edgeDriven, phaseWrap, bitDone;

  assign baseTick   = extQ ? pinRise : tick;
  assign edgeDriven = syncQ & extQ;
  assign phaseWrap  = baseTick & (phaseQ == PH_LAST);
  assign bitDone    = busyQ & (edgeDriven ? pinFall : phaseWrap);

  assign strb.load  = start & ~busyQ;
  assign strb.shift = bitDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      syncQ  <= 1'b0;
      extQ   <= 1'b0;
      leftQ  <= '0;
      phaseQ <= '0;
    end else if (strb.load) begin
      busyQ  <= 1'b1;
      syncQ  <= syncIn;
      extQ   <= extIn;
      leftQ  <= lenIn;
      phaseQ <= '0;
    end else if (busyQ) begin
      if (bitDone) begin
        leftQ <= leftQ - 1'b1;
        if (leftQ == CNT_W'(1)) busyQ <= 1'b0;
      end
      if (!edgeDriven && baseTick) begin
        phaseQ <= phaseWrap ? '0 : phaseQ + 1'b1;
      end
    end
  end

  assign busy        = busyQ;
  assign clkPhaseOut = busyQ ? (phaseQ >= PH_HALF) : 1'b1;
  assign frameSync   = syncQ;
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] txData,
  input  logic              addrFlagIn,
  input  logic              modeSync,
  input  logic              char7,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              addrFlagEn,
  input  logic              stop2,
  input  logic [1:0]        clkSel,
  input  logic              serClkIn,
  output logic              serOut,
  output logic              busy,
  output logic              serClkOut,
  output logic              serClkOe
);
  localparam int CNT_W = $clog2(DATA_W + 5);

  txFmtT            fmt;
  txStrbT           strb;
  logic [CNT_W-1:0] frameLen;
  logic             pinRise, pinFall, frameSync;

  assign fmt = '{syncMode: modeSync, char7: char7, parEn: parEn,
                 parOdd: parOdd, addrEn: addrFlagEn, stop2: stop2};

  frame_tx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (serClkIn),
    .riseSeen (pinRise),
    .fallSeen (pinFall)
  );

  frame_tx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .syncIn      (modeSync),
    .extIn       (clkSel[1]),
    .lenIn       (frameLen),
    .tick        (tick),
    .pinRise     (pinRise),
    .pinFall     (pinFall),
    .strb        (strb),
    .busy        (busy),
    .clkPhaseOut (serClkOut),
    .frameSync   (frameSync)
  );

  frame_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .fmtIn    (fmt),
    .dataIn   (txData),
    .flagIn   (addrFlagIn),
    .frameLen (frameLen),
    .lineOut  (serOut)
  );

  // Pin direction follows the live configuration.
  assign serClkOe = modeSync ? ~clkSel[1] : (clkSel == 2'b01);
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DATA_W-1:0] txData,
  input logic              modeSync,
  input logic              serOut,
  input logic              busy,
  input logic              serClkOut,
  input logic              frameSync
);
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (serOut && serClkOut));

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_start_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !modeSync) |=> !serOut);

  p_stop_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(frameSync)) |-> $past(serOut));

  p_sync_lsb_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && modeSync) |=> (serOut == $past(txData[0])));
endmodule

bind frame_tx frame_tx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .txData    (txData),
  .modeSync  (modeSync),
  .serOut    (serOut),
  .busy      (busy),
  .serClkOut (serClkOut),
  .frameSync (frameSync)
);

// File: tb/test_frame_tx.sv
`timescale 1ns/1ps
module test_frame_tx;
  logic       clk = 0;
  logic       rstN = 0;
  logic       tick = 0;
  logic       start = 0;
  logic [7:0] txData = 0;
  logic       addrFlagIn = 0, modeSync = 0, char7 = 0, parEn = 0, parOdd = 0;
  logic       addrFlagEn = 0, stop2 = 0;
  logic [1:0] clkSel = 0;
  logic       serClkIn = 0;
  logic       serOut, busy, serClkOut, serClkOe;

  int checks = 0, failures = 0;
  int tickDiv = 1;
  int sckHalf = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  frame_tx i_frame_tx (
    .clk(clk), .rstN(rstN), .tick(tick), .start(start), .txData(txData),
    .addrFlagIn(addrFlagIn), .modeSync(modeSync), .char7(char7), .parEn(parEn),
    .parOdd(parOdd), .addrFlagEn(addrFlagEn), .stop2(stop2), .clkSel(clkSel),
    .serClkIn(serClkIn), .serOut(serOut), .busy(busy), .serClkOut(serClkOut),
    .serClkOe(serClkOe)
  );

  // Tick source: one pulse every tickDiv cycles.
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      cnt++;
      if (cnt >= tickDiv) begin tick = 1; cnt = 0; end
      else tick = 0;
    end
  end

  // External serial clock: toggles every sckHalf cycles, held low when 0.
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      if (sckHalf == 0) begin serClkIn = 0; cnt = 0; end
      else begin
        cnt++;
        if (cnt >= sckHalf) begin serClkIn = ~serClkIn; cnt = 0; end
      end
    end
  end

  // Behavioural reference model.
  int  q[$];
  bit  mBusy, mSync, mExt;
  int  mPhase;
  bit  h1, h2, h3;

  function automatic void buildFrame();
    int n = char7 ? 7 : 8;
    int p = 0;
    q.delete();
    if (modeSync) begin
      for (int i = 0; i < 8; i++) q.push_back(int'(txData[i]));
      return;
    end
    q.push_back(0);
    for (int i = 0; i < n; i++) begin
      q.push_back(int'(txData[i]));
      p ^= int'(txData[i]);
    end
    if (addrFlagEn) q.push_back(int'(addrFlagIn));
    else if (parEn) q.push_back(p ^ int'(parOdd));
    q.push_back(1);
    if (stop2) q.push_back(1);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete(); mBusy = 0; mSync = 0; mExt = 0; mPhase = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit rise, fall, strobe, bt;
      rise = h2 && !h3;
      fall = !h2 && h3;
      h3 = h2; h2 = h1; h1 = serClkIn;
      if (mBusy) begin
        strobe = 0;
        if (mSync && mExt) strobe = fall;
        else begin
          bt = mExt ? rise : tick;
          if (bt) begin
            if (mPhase == 15) begin mPhase = 0; strobe = 1; end
            else mPhase++;
          end
        end
        if (strobe) begin
          void'(q.pop_front());
          if (q.size() == 0) mBusy = 0;
        end
      end else if (start) begin
        buildFrame();
        mBusy = 1; mPhase = 0; mSync = modeSync; mExt = clkSel[1];
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    int eOut, eOe;
    eOut = (mBusy && q.size() > 0) ? q[0] : 1;
    eOe  = modeSync ? int'(!clkSel[1]) : int'(clkSel == 2'b01);
    chk("serOut", int'(serOut), eOut);
    chk("busy", int'(busy), int'(mBusy));
    chk("serClkOe R8/R11/R13", int'(serClkOe), eOe);
    if (serClkOe || !mBusy)
      chk("serClkOut", int'(serClkOut), mBusy ? int'(mPhase >= 8) : 1);
  end

  task automatic pulseStart(input logic [7:0] d);
    @(posedge clk); #1;
    txData = d; start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (5) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d);
    pulseStart(d);
    waitIdle();
  endtask

  task automatic setFmt(input logic s, input logic c7, input logic pe, input logic po,
                        input logic ae, input logic s2, input logic [1:0] cs);
    @(posedge clk); #1;
    modeSync = s; char7 = c7; parEn = pe; parOdd = po;
    addrFlagEn = ae; stop2 = s2; clkSel = cs;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    repeat (4) @(negedge clk);
    chk("R1 serOut in reset", int'(serOut), 1);
    chk("R1 busy in reset", int'(busy), 0);
    @(posedge clk); #1 rstN = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle serOut", int'(serOut), 1);

    // R3: async 8-bit and 7-bit characters
    curReq = "R3";
    setFmt(0, 0, 0, 0, 0, 0, 2'b00); sendFrame(8'hA5);
    setFmt(0, 1, 0, 0, 0, 0, 2'b00); sendFrame(8'hD3);

    // R4: parity over the bits actually sent
    curReq = "R4";
    setFmt(0, 0, 1, 0, 0, 0, 2'b00); sendFrame(8'h07);
    setFmt(0, 0, 1, 1, 0, 0, 2'b00); sendFrame(8'h07);
    setFmt(0, 1, 1, 1, 0, 0, 2'b00); sendFrame(8'h81);

    // R5: address flag replaces parity, latched at start
    curReq = "R5";
    setFmt(0, 0, 1, 0, 1, 0, 2'b00);
    addrFlagIn = 1; pulseStart(8'h3C); addrFlagIn = 0; waitIdle();
    addrFlagIn = 0; pulseStart(8'h3D); addrFlagIn = 1; waitIdle();
    addrFlagIn = 0;

    // R6: two stop bits
    curReq = "R6";
    setFmt(0, 1, 1, 0, 0, 1, 2'b00); sendFrame(8'h5A);
    setFmt(0, 0, 0, 0, 1, 1, 2'b00); addrFlagIn = 1; sendFrame(8'hF0); addrFlagIn = 0;

    // R7: sparse internal tick
    curReq = "R7";
    tickDiv = 3;
    setFmt(0, 0, 1, 1, 0, 0, 2'b00); sendFrame(8'h96);
    tickDiv = 1;

    // R8: driven bit-rate clock in async mode
    curReq = "R8";
    setFmt(0, 0, 0, 0, 0, 1, 2'b01); sendFrame(8'h4B);

    // R9: external 16x clock, tick ignored
    curReq = "R9";
    sckHalf = 2; tickDiv = 2;
    setFmt(0, 0, 1, 0, 0, 0, 2'b10); sendFrame(8'hC1);
    setFmt(0, 1, 0, 0, 0, 1, 2'b11); sendFrame(8'h2E);
    sckHalf = 0; tickDiv = 1;
    repeat (6) @(posedge clk);

    // R10 / R11: synchronous, driven clock, async fields ignored
    curReq = "R10";
    setFmt(1, 1, 1, 1, 1, 1, 2'b00); addrFlagIn = 1; sendFrame(8'hB7); addrFlagIn = 0;
    curReq = "R11";
    setFmt(1, 0, 0, 0, 0, 0, 2'b01); sendFrame(8'h69);

    // R12: synchronous, external clock
    curReq = "R12";
    sckHalf = 3;
    setFmt(1, 0, 1, 0, 0, 1, 2'b10); sendFrame(8'h8E);
    sckHalf = 0;
    repeat (6) @(posedge clk);

    // R2: start during a frame is ignored
    curReq = "R2";
    setFmt(0, 0, 1, 0, 0, 0, 2'b00);
    pulseStart(8'h55);
    repeat (30) @(posedge clk);
    pulseStart(8'hFF);
    waitIdle();
    chk("R2 idle after single frame", int'(busy), 0);

    // R13: format changes in mid-frame do not affect the frame
    curReq = "R13";
    setFmt(0, 0, 0, 0, 0, 0, 2'b00);
    pulseStart(8'hE4);
    repeat (20) @(posedge clk);
    #1 char7 = 1; parEn = 1; stop2 = 1; modeSync = 1; clkSel = 2'b10;
    waitIdle();
    setFmt(0, 0, 0, 0, 0, 0, 2'b00);
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule